// File: doc/BRIEF.md
# Two-Channel Orthonormal Lattice Analysis Filter Bank

This block splits a stream of signed samples, one per clock, into two subband streams at half the input rate. Incoming samples are grouped into pairs (an even-indexed sample followed by an odd-indexed one). Each pair passes through two rotation-like lattice stages with a one-pair delay on one branch between them. The stage coefficients are the two lattice angles of the four-tap maximally-regular orthonormal wavelet, quantized to -1.75 and 0.25. The two subbands come out as one pair of results with a valid strobe every second clock.

To avoid fractional bits, every stage is scaled by 4, so the coefficients become the integers -7 and 1 and every product is a shift and an add. Each stage matrix is symmetric and squares to a multiple of the identity. Because of that, the whole bank is inverted exactly by the same two stages applied in reverse order. The result is perfect reconstruction with the quantized coefficients and a fixed gain of 1105 (65 times 17). Outputs are carried at full precision, so no value ever wraps or saturates.

Top module: `qmf_lattice_analysis`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `vld_o` is 0 and both `y0_o` and `y1_o` are 0.
- R2: The first sample taken after reset release is even-indexed, x(0). Samples then alternate even and odd on every clock, and pair n is (x(2n), x(2n+1)).
- R3: Sample x(m) is taken at the m-th rising edge after release, counting from 0. Pair n is presented with `vld_o` = 1 for exactly one cycle, the cycle after edge 2n+2. `vld_o` is 0 in every other cycle.
- R4: y0 of pair n equals 16·x(2n) − 28·x(2n+1) − 7·x(2n−2) − 4·x(2n−1), where a sample with a negative index counts as 0.
- R5: y1 of pair n equals 4·x(2n) − 7·x(2n+1) + 28·x(2n−2) + 16·x(2n−1). The two channel taps obey h1(k) = (−1)^k·h0(3−k).
- R6: Between valid strobes, `y0_o` and `y1_o` hold the values of the last valid pair.
- R7: Let U = 4·y0[n] + y1[n] and V = y0[n+1] − 4·y1[n+1]. Then 4U − 7V = 1105·x(2n) and −7U − 4V = 1105·x(2n+1), for every input sequence.
- R8: Outputs are IN_W+7 bits signed and exact for full-scale inputs of either sign: no wrap, no saturation.
- R9: A reset asserted in the middle of a stream clears the pairing phase and the inter-stage delay. After release, the outputs depend only on samples taken after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one input sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the caller |
| x_i | input | IN_W | Signed input sample |
| y0_o | output | IN_W+7 | Signed first subband result |
| y1_o | output | IN_W+7 | Signed second subband result |
| vld_o | output | 1 | High for one cycle when a new result pair is presented |

## Verification
The bench builds the block with the default 12-bit input, so outputs are 19 bits wide. At this width, full-scale runs of +2047 and −2048 put the worst-case growth of both stages within reach of an exact comparison. A pseudo-random stream of a few hundred samples is checked against the tap equations and is also reconstructed by an inverse lattice in the bench, which confirms the exact 1105 gain. Impulse tests expose the individual taps. A reset in the middle of a stream, left at an odd phase with a full delay register, shows that both history and pairing restart.

// File: rtl/qmf_lat_pkg.sv
package qmf_lat_pkg;
  // Stage coefficients scaled by 4: -1.75 -> -7, 0.25 -> 1
  localparam int K_FIRST  = -7;
  localparam int K_SECOND = 1;
  localparam int K_SCALE  = 4;

  // Bits added by one stage: |4a + k*b| <= (4 + |k|) * max|input|
  function automatic int stage_grow(input int k);
    int mag;
    mag = (k < 0) ? -k : k;
    return $clog2(K_SCALE + mag);
  endfunction
endpackage

// File: rtl/qmf_phase_split.sv
module qmf_phase_split #(
  parameter int IN_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic signed [IN_W-1:0] x_i,
  output logic signed [IN_W-1:0] even_o,
  output logic                   odd_phase_o
);
  logic                   phase_q, phase_d;
  logic signed [IN_W-1:0] even_q, even_d;

  always_comb begin
    phase_d = ~phase_q;
    even_d  = even_q;
    if (!phase_q) even_d = x_i;   // capture enable: even slot only
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      even_q  <= '0;
    end else begin
      phase_q <= phase_d;
      even_q  <= even_d;
    end
  end

  assign even_o      = even_q;
  assign odd_phase_o = phase_q;

  // R2: even and odd roles alternate every clock
  a_r2_phase_to_odd: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_q |=> phase_q);
  a_r2_phase_to_even: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |=> !phase_q);
  // R2: the even register moves only on an even slot
  a_r2_even_hold: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |=> $stable(even_q));
endmodule

// File: rtl/qmf_lattice_stage.sv
module qmf_lattice_stage #(
  parameter int IN_W  = 12,
  parameter int K     = -7,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  a_i,
  input  logic signed [IN_W-1:0]  b_i,
  output logic signed [OUT_W-1:0] a_o,
  output logic signed [OUT_W-1:0] b_o
);
  logic signed [OUT_W-1:0] a_x, b_x, k_a, k_b;

  assign a_x = OUT_W'(a_i);
  assign b_x = OUT_W'(b_i);

  generate
    if (K == -7) begin : g_neg_seven
      // -7*v = v - 8*v
      assign k_a = a_x - (a_x <<< 3);
      assign k_b = b_x - (b_x <<< 3);
    end else if (K == 1) begin : g_unit
      assign k_a = a_x;
      assign k_b = b_x;
    end else begin : g_generic
      assign k_a = OUT_W'(a_x * K);
      assign k_b = OUT_W'(b_x * K);
    end
  endgenerate

  // a' = 4a + K b ; b' = K a - 4b
  assign a_o = (a_x <<< 2) + k_b;
  assign b_o = k_a - (b_x <<< 2);

  // R7: the stage matrix squares to (16+K^2)·I, so its inverse is itself scaled
  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      a_r7_stage_inverse_a: assert ((4 * longint'(a_o) + K * longint'(b_o))
                                    == (16 + K * K) * longint'(a_i));
      a_r7_stage_inverse_b: assert ((K * longint'(a_o) - 4 * longint'(b_o))
                                    == (16 + K * K) * longint'(b_i));
    end
  end
endmodule

// File: rtl/qmf_lattice_analysis.sv
module qmf_lattice_analysis
  import qmf_lat_pkg::*;
#(
  parameter int IN_W = 12
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic signed [IN_W-1:0]               x_i,
  output logic signed [IN_W+stage_grow(K_FIRST)+stage_grow(K_SECOND)-1:0] y0_o,
  output logic signed [IN_W+stage_grow(K_FIRST)+stage_grow(K_SECOND)-1:0] y1_o,
  output logic                                 vld_o
);
  localparam int W0 = IN_W + stage_grow(K_FIRST);
  localparam int W1 = W0 + stage_grow(K_SECOND);

  logic signed [IN_W-1:0] even_s;
  logic                   odd_s;
  logic signed [W0-1:0]   s0_a, s0_b;
  logic signed [W0-1:0]   u_q, v_q, vd_q, u_d, v_d, vd_d;
  logic                   full_q, full_d;
  logic signed [W1-1:0]   s1_a, s1_b;
  logic signed [W1-1:0]   y0_q, y1_q, y0_d, y1_d;
  logic                   vld_q, vld_d;

  qmf_phase_split #(.IN_W(IN_W)) u_split (
    .clk(clk), .rst_n(rst_n), .x_i(x_i),
    .even_o(even_s), .odd_phase_o(odd_s)
  );

  qmf_lattice_stage #(.IN_W(IN_W), .K(K_FIRST), .OUT_W(W0)) u_stage0 (
    .a_i(even_s), .b_i(x_i), .a_o(s0_a), .b_o(s0_b)
  );

  qmf_lattice_stage #(.IN_W(W0), .K(K_SECOND), .OUT_W(W1)) u_stage1 (
    .a_i(u_q), .b_i(vd_q), .a_o(s1_a), .b_o(s1_b)
  );

  always_comb begin
    u_d    = u_q;
    v_d    = v_q;
    vd_d   = vd_q;
    full_d = full_q;
    y0_d   = y0_q;
    y1_d   = y1_q;
    vld_d  = 1'b0;
    if (odd_s) begin            // pair complete: first stage result
      u_d    = s0_a;
      v_d    = s0_b;
      vd_d   = v_q;             // one-pair delay on the lower branch
      full_d = 1'b1;
    end
    if (!odd_s && full_q) begin // second stage result
      y0_d  = s1_a;
      y1_d  = s1_b;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_q    <= '0;
      v_q    <= '0;
      vd_q   <= '0;
      full_q <= 1'b0;
      y0_q   <= '0;
      y1_q   <= '0;
      vld_q  <= 1'b0;
    end else begin
      u_q    <= u_d;
      v_q    <= v_d;
      vd_q   <= vd_d;
      full_q <= full_d;
      y0_q   <= y0_d;
      y1_q   <= y1_d;
      vld_q  <= vld_d;
    end
  end

  assign y0_o  = y0_q;
  assign y1_o  = y1_q;
  assign vld_o = vld_q;

  // R3: a strobe never lasts two cycles
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o);
  // R3: a strobe coincides with the odd slot of the splitter
  a_r3_strobe_slot: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> odd_s);
  // R6: results hold after their strobe
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> ($stable(y0_o) && $stable(y1_o)));
  // R1: no strobe before the first pair has passed the first stage
  a_r1_no_early_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !full_q |=> !vld_o);
endmodule

// File: tb/qmf_lattice_analysis_tb.sv
`timescale 1ns/1ps
module qmf_lattice_analysis_tb;
  localparam int IN_W  = 12;
  localparam int OUT_W = IN_W + 7;
  localparam int MAXS  = 400;
  localparam int NTBL  = 5;
  // each row: even sample, odd sample, expected y0, expected y1
  localparam int TBL [NTBL][4] = '{
    '{   1,   0,   16,    4},
    '{   0,   1,  -35,   21},
    '{   0,   0,   -4,   16},
    '{ 100, -50, 3000,  750},
    '{  -3,   2, -604, 1974}
  };

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic signed [IN_W-1:0]  x_i = '0;
  logic signed [OUT_W-1:0] y0, y1;
  logic                    vld;

  int     n_chk = 0, n_bad = 0;
  bit     done  = 1'b0;
  int     xs [0:MAXS-1];
  longint ya [0:MAXS/2+2];
  longint yb [0:MAXS/2+2];
  int     nsamp, npairs;

  always #2 clk = ~clk;

  qmf_lattice_analysis #(.IN_W(IN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .x_i(x_i), .y0_o(y0), .y1_o(y1), .vld_o(vld)
  );

  task automatic chk(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic longint xv(input int m);
    if (m < 0 || m >= nsamp) return 0;
    return longint'(xs[m]);
  endfunction

  function automatic longint ey0(input int n);
    return 16*xv(2*n) - 28*xv(2*n+1) - 7*xv(2*n-2) - 4*xv(2*n-1);
  endfunction

  function automatic longint ey1(input int n);
    return 4*xv(2*n) - 7*xv(2*n+1) + 28*xv(2*n-2) + 16*xv(2*n-1);
  endfunction

  // reset, stream xs[0..n-1] then zeros, capture every strobed pair
  task automatic run_seq(input int n);
    int     cad_err = 0;
    int     hold_err = 0;
    int     np = 0;
    longint l0 = 0, l1 = 0;
    bit     expv;
    nsamp = n;
    rst_n = 1'b0;
    x_i   = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int m = 0; m < n + 4; m++) begin
      if (m > 0) @(negedge clk);
      if (m == 0) begin
        chk("R1 vld after reset", longint'(vld), 0);
        chk("R1 y0 after reset", longint'(y0), 0);
        chk("R1 y1 after reset", longint'(y1), 0);
      end
      expv = (m >= 3) && (m % 2 == 1);
      if (vld !== expv) cad_err++;
      if (vld) begin
        ya[np] = longint'(y0);
        yb[np] = longint'(y1);
        l0 = ya[np];
        l1 = yb[np];
        np++;
      end else if (m >= 4 && (longint'(y0) != l0 || longint'(y1) != l1)) begin
        hold_err++;
      end
      x_i = (m < n) ? IN_W'(xs[m]) : '0;
    end
    npairs = np;
    chk("R3 strobe cadence errors", cad_err, 0);
    chk("R6 hold errors", hold_err, 0);
    chk("R3 pair count", np, n/2 + 1);
  endtask

  task automatic check_taps(input string tag);
    for (int n = 0; n < npairs; n++) begin
      chk({tag, " R4 y0"}, ya[n], ey0(n));
      chk({tag, " R5 y1"}, yb[n], ey1(n));
    end
  endtask

  task automatic check_pr();
    longint u, v;
    for (int n = 0; n + 1 < npairs; n++) begin
      u = 4*ya[n] + yb[n];
      v = ya[n+1] - 4*yb[n+1];
      chk("R7 even reconstruction", 4*u - 7*v, 1105*xv(2*n));
      chk("R7 odd reconstruction", -7*u - 4*v, 1105*xv(2*n+1));
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    // vector table, walked by one loop (R2 pairing, R4, R5)
    for (int r = 0; r < NTBL; r++) begin
      xs[2*r]   = TBL[r][0];
      xs[2*r+1] = TBL[r][1];
    end
    run_seq(2*NTBL);
    for (int r = 0; r < NTBL; r++) begin
      chk("R2 R4 table y0", ya[r], longint'(TBL[r][2]));
      chk("R2 R5 table y1", yb[r], longint'(TBL[r][3]));
    end

    // odd-slot impulse: taps -28,-4 and -7,16 (R5 mirror relation)
    xs[0] = 0; xs[1] = 1;
    run_seq(2);
    chk("R4 odd impulse y0[0]", ya[0], -28);
    chk("R5 odd impulse y1[0]", yb[0], -7);
    chk("R4 odd impulse y0[1]", ya[1], -4);
    chk("R5 odd impulse y1[1]", yb[1], 16);

    // pseudo-random stream (R4, R5, R7)
    seed = 32'h1234_5678;
    for (int m = 0; m < MAXS; m++) begin
      seed  = seed * 32'd1103515245 + 32'd12345;
      xs[m] = int'($signed(seed[IN_W+15:16]));
    end
    run_seq(MAXS);
    check_taps("random");
    check_pr();

    // full-scale extremes (R8)
    for (int m = 0; m < 16; m++)
      xs[m] = (m < 8) ? ((m % 2 == 0) ? 2047 : -2048) : -2048;
    xs[16] = 2047; xs[17] = 2047; xs[18] = -2048; xs[19] = 2047;
    run_seq(20);
    check_taps("R8 extremes");
    check_pr();

    // reset in mid-stream at odd phase with a loaded delay (R9)
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int m = 0; m < 7; m++) begin
      x_i = IN_W'(1500 - 700*m);
      @(negedge clk);
    end
    xs[0] = 1; xs[1] = 0;
    run_seq(2);
    chk("R9 y0[0] after mid-stream reset", ya[0], 16);
    chk("R9 y1[0] after mid-stream reset", yb[0], 4);
    chk("R9 y0[1] after mid-stream reset", ya[1], -7);
    chk("R9 y1[1] after mid-stream reset", yb[1], 28);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule